// File: doc/BRIEF.md
# Register Modification History Logger

This block keeps a short record of which general registers an instruction has stepped through auto-increment or auto-decrement addressing, and by how much. When an instruction is aborted part-way, fault recovery software reads this record to undo the register side effects and restart the instruction. A companion register holds the address the current instruction was fetched from.

Each adjustment is packed into one byte: the register index and a signed 5-bit step. A new byte enters at the low end of a 16-bit history register and pushes the older byte up, so the two most recent adjustments are kept. The step can be given directly or worked out by the block from the addressing kind, the byte/word width and the deferred flag. A fetch strobe clears the history and captures the fetch address. While any of the three fault flags is set, both registers are frozen so the record of the failing instruction survives until software reads it.

The adjustment port is a valid/ready stream. The block never applies back-pressure: `adj_ready` is held high, and every beat with `adj_valid` high is consumed on that clock edge, even when it is then dropped. The fetch strobe and fault flags are plain control pins. Both readback outputs come straight from registers and change one clock edge after the input that caused the change.

Top module: `reg_mod_logger`

## Requirements
- R1: After reset both `hist_q` and `insn_addr_q` read zero.
- R2: An accepted adjustment forms the byte {step[4:0] in bits 7:3, register index in bits 2:0}. The history shifts left by 8 and takes the byte in bits 7:0, and the byte that was in bits 15:8 is lost.
- R3: With `adj_kind` 01 (post-increment) and 10 (pre-decrement), a word access that is not deferred logs a step of +2 and -2 respectively.
- R4: For a byte access (`adj_byte`=1) that is not deferred, the step magnitude is 1 for registers 0 to 5 and 2 for registers 6 and 7.
- R5: A deferred access (`adj_defer`=1) always logs a magnitude of 2, whatever the value of `adj_byte`.
- R6: With `adj_kind` 00 the 5-bit two's complement `adj_amt` is logged unchanged, over the whole range -16 to +15.
- R7: With `adj_kind` 11 the beat is consumed and no entry is logged.
- R8: A fetch strobe (`insn_valid`) clears `hist_q` and loads `insn_addr_q` with `insn_addr`.
- R9: If a fetch strobe and an adjustment beat arrive in the same cycle, the fetch wins and the adjustment is discarded.
- R10: While any bit of `fault_flags` is high, neither register changes on adjustments or fetch strobes.
- R11: `adj_ready` is always high, in reset and while frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adj_valid | input | 1 | Adjustment beat present |
| adj_ready | output | 1 | Adjustment beat accepted (constant high) |
| adj_kind | input | 2 | 00 direct, 01 post-increment, 10 pre-decrement, 11 no log |
| adj_reg | input | 3 | Index of the register adjusted |
| adj_byte | input | 1 | Byte-width access |
| adj_defer | input | 1 | Deferred addressing |
| adj_amt | input | 5 | Signed step used when `adj_kind` is 00 |
| insn_valid | input | 1 | New instruction fetch strobe |
| insn_addr | input | 16 | Fetch address of the new instruction |
| fault_flags | input | 3 | Abort flags; any bit high freezes both registers |
| hist_q | output | 16 | Adjustment history, newest entry in the low byte |
| insn_addr_q | output | 16 | Address of the current instruction |

## Verification
Two pairs of functions can fall in the same cycle. A fetch strobe and an adjustment beat are driven on the same clock edge over a history that already holds data, and the result must be an empty history with the new address loaded. A fault flag is held high together with both an adjustment and a fetch, and both readback values must match the values from before the flag rose. After the flag drops, one further adjustment shows that logging has resumed.

// File: rtl/reg_mod_logger_pkg.sv
package reg_mod_logger_pkg;
  typedef enum logic [1:0] {
    KIND_DIRECT  = 2'b00,
    KIND_POSTINC = 2'b01,
    KIND_PREDEC  = 2'b10,
    KIND_NOLOG   = 2'b11
  } adj_kind_e;
endpackage

// File: rtl/rml_step_decode.sv
module rml_step_decode
  import reg_mod_logger_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int STEP_W  = 5,
  parameter int NARROW_LIMIT = 6
) (
  input  logic [1:0]        kind,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              byte_acc,
  input  logic              deferred,
  input  logic [STEP_W-1:0] direct_amt,
  output logic              loggable,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);
  localparam logic [STEP_W-1:0] TWO = STEP_W'(2);

  logic              narrow;
  logic [STEP_W-1:0] mag;

  always_comb begin
    narrow = byte_acc && !deferred && (int'(reg_idx) < NARROW_LIMIT);
    mag    = narrow ? ONE : TWO;
    loggable = 1'b1;
    unique case (adj_kind_e'(kind))
      KIND_DIRECT:  step = direct_amt;
      KIND_POSTINC: step = mag;
      KIND_PREDEC:  step = -mag;
      default: begin
        step     = '0;
        loggable = 1'b0;
      end
    endcase
  end

  // R5: deferred addressing never yields a unit step
  always_comb begin
    if (deferred && (kind == KIND_POSTINC))
      assert_defer_two_R5: assert (step != ONE);
  end
endmodule

// File: rtl/rml_history.sv
module rml_history #(
  parameter int ENTRY_W = 8,
  parameter int ENTRIES = 2,
  localparam int HIST_W = ENTRY_W * ENTRIES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               clr_en,
  input  logic [ENTRY_W-1:0] entry,
  output logic [HIST_W-1:0]  hist_q
);
  logic [HIST_W-1:0] hist_d;

  generate
    if (ENTRIES > 1) begin : g_multi
      always_comb hist_d = {hist_q[HIST_W-ENTRY_W-1:0], entry};
    end else begin : g_single
      always_comb hist_d = entry;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (clr_en)   hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  generate
    if (ENTRIES > 1) begin : g_chk
      assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr_en) |=>
          hist_q[HIST_W-1:ENTRY_W] == $past(hist_q[HIST_W-ENTRY_W-1:0]));
    end
  endgenerate

  assert_newest_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr_en) |=> hist_q[ENTRY_W-1:0] == $past(entry));
endmodule

// File: rtl/rml_addr_reg.sv
module rml_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (load_en) addr_q <= addr_in;
  end

  assert_addr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> addr_q == $past(addr_in));
endmodule

// File: rtl/reg_mod_logger.sv
module reg_mod_logger
  import reg_mod_logger_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int STEP_W  = 5,
  parameter int ENTRIES = 2,
  parameter int ADDR_W  = 16,
  parameter int FLAG_W  = 3,
  localparam int ENTRY_W = IDX_W + STEP_W,
  localparam int HIST_W  = ENTRY_W * ENTRIES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adj_valid,
  output logic              adj_ready,
  input  logic [1:0]        adj_kind,
  input  logic [IDX_W-1:0]  adj_reg,
  input  logic              adj_byte,
  input  logic              adj_defer,
  input  logic [STEP_W-1:0] adj_amt,
  input  logic              insn_valid,
  input  logic [ADDR_W-1:0] insn_addr,
  input  logic [FLAG_W-1:0] fault_flags,
  output logic [HIST_W-1:0] hist_q,
  output logic [ADDR_W-1:0] insn_addr_q
);
  logic              frozen;
  logic              loggable;
  logic [STEP_W-1:0] step;
  logic              fetch_en;
  logic              log_en;
  logic [ENTRY_W-1:0] entry;

  assign adj_ready = 1'b1;
  assign frozen    = |fault_flags;
  assign fetch_en  = insn_valid && !frozen;
  assign log_en    = adj_valid && loggable && !insn_valid && !frozen;
  assign entry     = {step, adj_reg};

  rml_step_decode #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_step (
    .kind       (adj_kind),
    .reg_idx    (adj_reg),
    .byte_acc   (adj_byte),
    .deferred   (adj_defer),
    .direct_amt (adj_amt),
    .loggable   (loggable),
    .step       (step)
  );

  rml_history #(.ENTRY_W(ENTRY_W), .ENTRIES(ENTRIES)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (log_en),
    .clr_en   (fetch_en),
    .entry    (entry),
    .hist_q   (hist_q)
  );

  rml_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (fetch_en),
    .addr_in (insn_addr),
    .addr_q  (insn_addr_q)
  );

  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(hist_q) && $stable(insn_addr_q)));

  assert_fetch_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && adj_valid && !frozen) |=> hist_q == '0);

  assert_nolog_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_valid && adj_kind == KIND_NOLOG && !insn_valid) |=> $stable(hist_q));

  assert_always_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adj_ready);
endmodule

// File: tb/reg_mod_logger_tb.sv
module reg_mod_logger_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adj_valid = 1'b0;
  logic        adj_ready;
  logic [1:0]  adj_kind = 2'b00;
  logic [2:0]  adj_reg = 3'd0;
  logic        adj_byte = 1'b0;
  logic        adj_defer = 1'b0;
  logic [4:0]  adj_amt = 5'd0;
  logic        insn_valid = 1'b0;
  logic [15:0] insn_addr = 16'd0;
  logic [2:0]  fault_flags = 3'd0;
  logic [15:0] hist_q;
  logic [15:0] insn_addr_q;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_mod_logger u_dut (
    .clk(clk), .rst_n(rst_n), .adj_valid(adj_valid), .adj_ready(adj_ready),
    .adj_kind(adj_kind), .adj_reg(adj_reg), .adj_byte(adj_byte),
    .adj_defer(adj_defer), .adj_amt(adj_amt), .insn_valid(insn_valid),
    .insn_addr(insn_addr), .fault_flags(fault_flags), .hist_q(hist_q),
    .insn_addr_q(insn_addr_q)
  );

  function automatic logic [7:0] ent(input int r, input int amt);
    logic [4:0] a;
    a = 5'(amt);
    return {a, 3'(r)};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one beat: drive at negedge, registers update at next posedge, sample at following negedge
  task automatic adj(input logic [1:0] k, input int r, input logic b, input logic d, input int amt);
    adj_valid = 1'b1; adj_kind = k; adj_reg = 3'(r);
    adj_byte = b; adj_defer = d; adj_amt = 5'(amt);
    @(negedge clk);
    adj_valid = 1'b0;
  endtask

  task automatic fetch(input logic [15:0] a);
    insn_valid = 1'b1; insn_addr = a;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 hist", hist_q, 16'h0);
    check("R1 addr", insn_addr_q, 16'h0);
    check("R11 ready in reset", {15'd0, adj_ready}, 16'h1);
  endtask

  task automatic t_word_steps();
    fetch(16'h0100);
    adj(2'b01, 3, 1'b0, 1'b0, 0);
    check("R3 inc word", hist_q, {8'h00, ent(3, 2)});
    adj(2'b10, 5, 1'b0, 1'b0, 0);
    check("R3 dec word / R2 shift", hist_q, {ent(3, 2), ent(5, -2)});
    adj(2'b01, 0, 1'b1, 1'b0, 0);
    check("R2 oldest dropped", hist_q, {ent(5, -2), ent(0, 1)});
  endtask

  task automatic t_byte_steps();
    fetch(16'h0200);
    adj(2'b01, 5, 1'b1, 1'b0, 0);
    check("R4 byte r5 inc", hist_q, {8'h00, ent(5, 1)});
    adj(2'b01, 6, 1'b1, 1'b0, 0);
    check("R4 byte r6 inc", hist_q, {ent(5, 1), ent(6, 2)});
    adj(2'b10, 7, 1'b1, 1'b0, 0);
    check("R4 byte r7 dec", hist_q, {ent(6, 2), ent(7, -2)});
    adj(2'b10, 1, 1'b1, 1'b0, 0);
    check("R4 byte r1 dec", hist_q, {ent(7, -2), ent(1, -1)});
  endtask

  task automatic t_deferred();
    fetch(16'h0300);
    adj(2'b10, 2, 1'b1, 1'b1, 0);
    check("R5 deferred byte dec", hist_q, {8'h00, ent(2, -2)});
    adj(2'b01, 4, 1'b1, 1'b1, 0);
    check("R5 deferred byte inc", hist_q, {ent(2, -2), ent(4, 2)});
  endtask

  task automatic t_direct();
    fetch(16'h0400);
    adj(2'b00, 1, 1'b0, 1'b0, -16);
    check("R6 direct -16", hist_q, {8'h00, ent(1, -16)});
    adj(2'b00, 4, 1'b1, 1'b1, 15);
    check("R6 direct +15", hist_q, {ent(1, -16), ent(4, 15)});
  endtask

  task automatic t_nolog();
    adj(2'b11, 6, 1'b0, 1'b0, 7);
    check("R7 no entry", hist_q, {ent(1, -16), ent(4, 15)});
  endtask

  task automatic t_fetch();
    fetch(16'hBEEF);
    check("R8 hist cleared", hist_q, 16'h0);
    check("R8 addr loaded", insn_addr_q, 16'hBEEF);
  endtask

  task automatic t_collide();
    adj(2'b01, 2, 1'b0, 1'b0, 0);
    adj_valid = 1'b1; adj_kind = 2'b10; adj_reg = 3'd3; adj_byte = 1'b0; adj_defer = 1'b0;
    insn_valid = 1'b1; insn_addr = 16'h1234;
    @(negedge clk);
    adj_valid = 1'b0; insn_valid = 1'b0;
    check("R9 fetch wins hist", hist_q, 16'h0);
    check("R9 fetch wins addr", insn_addr_q, 16'h1234);
  endtask

  task automatic t_freeze();
    adj(2'b01, 1, 1'b0, 1'b0, 0);
    for (int f = 1; f < 8; f += 3) begin
      fault_flags = 3'(f);
      adj(2'b10, 6, 1'b0, 1'b0, 0);
      fetch(16'h5555);
      check("R10 hist held", hist_q, {8'h00, ent(1, 2)});
      check("R10 addr held", insn_addr_q, 16'h1234);
      check("R11 ready frozen", {15'd0, adj_ready}, 16'h1);
    end
    fault_flags = 3'd0;
    adj(2'b10, 6, 1'b0, 1'b0, 0);
    check("R10 resumes", hist_q, {ent(1, 2), ent(6, -2)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_steps();
    t_byte_steps();
    t_deferred();
    t_direct();
    t_nolog();
    t_fetch();
    t_collide();
    t_freeze();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule